// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Write Controller

This block sits between a serial bus front-end and a non-volatile byte array organised as pages of sixteen bytes. While a write transaction is open, it gathers the incoming data bytes in a buffer that holds one page, with a valid flag for each byte slot. Nothing reaches the array until the STOP that closes the transaction. At that point, if at least one non-volatile byte was gathered, the block runs one internal programming cycle of fixed length. Throughout that cycle the block holds `busy` high, which tells the front-end to disregard the bus lines and leave SDA released. At the end of the cycle the whole page is committed in a single step.

The first accepted byte of a transaction picks the page and the starting slot. Each later byte goes to the next slot, and the slot wraps back to the start of the same page after the last one. Bytes flagged as volatile are handled by other logic and are not buffered. A transaction that buffered nothing ends without a busy period. A START that arrives before the STOP throws away whatever was gathered. The array is a register model that starts erased and has a one-cycle registered read port.

The state machine has four states:
- `ST_STANDBY`: idle. A START moves it to `ST_COLLECT`.
- `ST_COLLECT`: gathering bytes.
  - Another START restarts it in `ST_COLLECT` and clears the buffer.
  - A STOP moves it to `ST_PROGRAM` when any slot is valid, and back to `ST_STANDBY` otherwise.
- `ST_PROGRAM`: the programming timer is running. Timer expiry moves it to `ST_COMMIT`.
- `ST_COMMIT`: one cycle in which the page is written. It then always returns to `ST_STANDBY`.

Top module: `nvw_page_commit`

## Requirements
- R1: After reset `busy` and `commit_en` are 0, and every array byte reads 8'hFF.
- R2: The first non-volatile byte after START is stored at page `byte_addr[ADDR_W-1:OFF_W]` and slot `byte_addr[OFF_W-1:0]`. Each later byte goes to the next slot, and its `byte_addr` is ignored. A first byte at slot 15 commits only that slot.
- R3: A slot that passes slot 15 wraps to slot 0 of the same page. A byte that lands on an already-filled slot replaces the earlier value.
- R4: The array does not change before STOP. `busy` is 1 starting with the cycle after the STOP edge, and it stays 1 for exactly PROG_CYCLES+1 cycles.
- R5: Each programming cycle produces exactly one `commit_en` pulse, in the last busy cycle. The pulse carries the page and a mask with bit i set for each written slot i. The array holds the new data afterwards.
- R6: Slots of the page that were not written in the transaction keep their previous contents.
- R7: A byte presented with `byte_volatile`=1 is not buffered. A transaction made only of such bytes produces no busy cycle.
- R8: A START followed by STOP with no data bytes produces no busy cycle and no commit.
- R9: A START during an open transaction discards the bytes gathered so far. Only bytes after the newest START are committed.
- R10: While `busy` is 1, START, STOP and byte strobes have no effect. No second programming cycle follows, and strobed bytes do not reach the array.
- R11: Byte strobes outside a transaction (no START since the last STOP or commit) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle START event from the front-end |
| xfer_stop | input | 1 | One-cycle STOP event from the front-end |
| byte_we | input | 1 | Data byte strobe |
| byte_addr | input | ADDR_W | Byte address (page and slot) |
| byte_wdata | input | 8 | Data byte |
| byte_volatile | input | 1 | Byte targets a volatile register |
| busy | output | 1 | Programming in progress; the bus side must be frozen |
| commit_en | output | 1 | One-cycle page commit strobe |
| commit_page | output | PAGE_W | Page being committed |
| commit_mask | output | PAGE_BYTES | Per-slot write enables |
| commit_data | output | PAGE_BYTES*8 | Page data, slot i in bits [8i+7:8i] |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, one cycle after `rd_addr` |

## Verification
The bench builds the block with PAGES=16, PAGE_BYTES=16 and PROG_CYCLES=12. With only twelve programming cycles, the whole busy window can be counted cycle by cycle. It also leaves room to inject START, bytes and STOP inside that window and still watch it close. Sixteen pages keep the address at eight bits, so the bench can reach the last page and the last slot directly and read back whole pages to check preservation, wrap-around and discarded transactions.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_COMMIT  = 2'd3
    } nvw_state_e;

endpackage

// File: rtl/nvw_page_buffer.sv
module nvw_page_buffer
    import nvw_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int OFF_W  = 4,
    localparam int NB     = 1 << OFF_W,
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [PAGE_W-1:0]    page,
    output logic [NB-1:0]        valid,
    output logic [NB*BYTE_W-1:0] data
);

    logic [BYTE_W-1:0] bytes_q [NB];
    logic [NB-1:0]     valid_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [OFF_W-1:0]  slot;

    // the first byte takes its slot from the address, later ones follow the pointer
    always_comb begin
        if (valid_q == '0) begin
            slot = addr[OFF_W-1:0];
        end else begin
            slot = ptr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            page_q  <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < NB; i++) begin
                bytes_q[i] <= '0;
            end
        end else if (clear) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (load) begin
            if (valid_q == '0) begin
                page_q <= addr[ADDR_W-1:OFF_W];
            end
            bytes_q[slot] <= wdata;
            valid_q[slot] <= 1'b1;
            ptr_q         <= slot + OFF_W'(1);
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_flat
        assign data[g*BYTE_W +: BYTE_W] = bytes_q[g];
    end

    assign page  = page_q;
    assign valid = valid_q;

    // R3: once a page is chosen it stays fixed until the buffer is cleared
    assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q != '0 && !clear) |=> (page_q == $past(page_q)));

    // R2: an accepted byte always leaves at least one valid slot
    assert_load_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (valid_q != '0));

endmodule

// File: rtl/nvw_prog_timer.sv
module nvw_prog_timer #(
    parameter int CYCLES = 625000,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign done = run_q && (cnt_q == '0);

    // R4: a running count steps down by one each cycle
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !start) |=> (run_q && cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: completion stops the timer
    assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !run_q);

endmodule

// File: rtl/nvw_nv_array.sv
module nvw_nv_array
    import nvw_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int OFF_W  = 4,
    localparam int NB     = 1 << OFF_W,
    localparam int ADDR_W = PAGE_W + OFF_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_W-1:0]    wr_page,
    input  logic [NB-1:0]        wr_mask,
    input  logic [NB*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data
);

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_mask[b]) begin
                    mem_q[{wr_page, OFF_W'(b)}] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '1;
        end else begin
            rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/nvw_page_commit.sv
module nvw_page_commit
    import nvw_pkg::*;
#(
    parameter int PAGES       = 128,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 625000,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         xfer_start,
    input  logic                         xfer_stop,
    input  logic                         byte_we,
    input  logic [ADDR_W-1:0]            byte_addr,
    input  logic [BYTE_W-1:0]            byte_wdata,
    input  logic                         byte_volatile,
    output logic                         busy,
    output logic                         commit_en,
    output logic [PAGE_W-1:0]            commit_page,
    output logic [PAGE_BYTES-1:0]        commit_mask,
    output logic [PAGE_BYTES*BYTE_W-1:0] commit_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [BYTE_W-1:0]            rd_data
);

    nvw_state_e state_q, state_d;

    logic                         buf_clear;
    logic                         buf_load;
    logic [PAGE_W-1:0]            buf_page;
    logic [PAGE_BYTES-1:0]        buf_valid;
    logic [PAGE_BYTES*BYTE_W-1:0] buf_data;
    logic                         tmr_start;
    logic                         tmr_done;
    logic                         any_valid;

    assign any_valid = (buf_valid != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (xfer_start) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (xfer_start) begin
                    state_d = ST_COLLECT;
                end else if (xfer_stop) begin
                    state_d = any_valid ? ST_PROGRAM : ST_STANDBY;
                end
            end
            ST_PROGRAM: begin
                if (tmr_done) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_d = ST_STANDBY;
            end
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        buf_clear = 1'b0;
        buf_load  = 1'b0;
        tmr_start = 1'b0;
        busy      = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            ST_STANDBY: begin
                buf_clear = xfer_start;
            end
            ST_COLLECT: begin
                buf_clear = xfer_start;
                buf_load  = byte_we && !byte_volatile && !xfer_start;
                tmr_start = !xfer_start && xfer_stop && any_valid;
            end
            ST_PROGRAM: begin
                busy = 1'b1;
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                commit_en = 1'b1;
            end
        endcase
    end

    nvw_page_buffer #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W)
    ) u_buffer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (buf_clear),
        .load  (buf_load),
        .addr  (byte_addr),
        .wdata (byte_wdata),
        .page  (buf_page),
        .valid (buf_valid),
        .data  (buf_data)
    );

    nvw_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    nvw_nv_array #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_page (buf_page),
        .wr_mask (buf_valid),
        .wr_data (buf_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign commit_page = buf_page;
    assign commit_mask = buf_valid;
    assign commit_data = buf_data;

    // R4: an accepted STOP with buffered data raises busy on the next cycle
    assert_stop_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> busy);

    // R5: commit only inside the busy window, once, then standby
    assert_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> busy);
    assert_commit_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> (!commit_en && !busy));
    assert_commit_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (commit_mask != '0));

    // R8: STOP with an empty buffer never starts programming
    assert_empty_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && xfer_stop && !xfer_start && !any_valid) |=> !busy);

    // R10: the buffer is frozen while busy
    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(buf_valid) && $stable(commit_page)));

    // R11: outside a transaction the buffer only changes through START
    assert_idle_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && !xfer_start) |=> $stable(buf_valid));

endmodule

// File: tb/nvw_page_commit_tb.sv
module nvw_page_commit_tb;

    localparam int PAGES  = 16;
    localparam int PB     = 16;
    localparam int PC     = 12;
    localparam int PAGE_W = 4;
    localparam int OFF_W  = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0;
    logic              xfer_stop = 1'b0;
    logic              byte_we = 1'b0;
    logic [ADDR_W-1:0] byte_addr = '0;
    logic [7:0]        byte_wdata = '0;
    logic              byte_volatile = 1'b0;
    logic              busy;
    logic              commit_en;
    logic [PAGE_W-1:0] commit_page;
    logic [PB-1:0]     commit_mask;
    logic [PB*8-1:0]   commit_data;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    int checks = 0;
    int fails  = 0;
    int busy_mon = 0;
    int commit_mon = 0;
    logic [PAGE_W-1:0] last_page = '0;
    logic [PB-1:0]     last_mask = '0;
    logic [7:0] exp_mem [PAGES*PB];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nvw_page_commit #(
        .PAGES       (PAGES),
        .PAGE_BYTES  (PB),
        .PROG_CYCLES (PC)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_start    (xfer_start),
        .xfer_stop     (xfer_stop),
        .byte_we       (byte_we),
        .byte_addr     (byte_addr),
        .byte_wdata    (byte_wdata),
        .byte_volatile (byte_volatile),
        .busy          (busy),
        .commit_en     (commit_en),
        .commit_page   (commit_page),
        .commit_mask   (commit_mask),
        .commit_data   (commit_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data)
    );

    // passive monitor sampled away from the active edge
    always @(negedge clk) begin
        if (busy) busy_mon = busy_mon + 1;
        if (commit_en) begin
            commit_mon = commit_mon + 1;
            last_page  = commit_page;
            last_mask  = commit_mask;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start();
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    endtask

    task automatic do_stop();
        xfer_stop = 1'b1; tick(); xfer_stop = 1'b0;
    endtask

    task automatic do_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic vol);
        byte_we = 1'b1; byte_addr = a; byte_wdata = d; byte_volatile = vol;
        tick();
        byte_we = 1'b0; byte_volatile = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        rd_addr = a; tick(); d = rd_data;
    endtask

    task automatic check_page(input int pg, input string req);
        logic [7:0] d;
        for (int o = 0; o < PB; o++) begin
            rd(ADDR_W'(pg*PB + o), d);
            chk(req, $sformatf("page %0d slot %0d", pg, o), d, exp_mem[pg*PB + o]);
        end
    endtask

    // STOP, then watch the whole busy window; returns busy cycles and commits
    task automatic stop_and_wait(output int bc, output int cc, output logic first_busy);
        int b0, c0;
        b0 = busy_mon; c0 = commit_mon;
        do_stop();
        first_busy = busy;
        repeat (PC + 10) tick();
        bc = busy_mon - b0;
        cc = commit_mon - c0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "commit_en after reset", commit_en, 0);
        rd(8'h00, d);  chk("R1", "array byte 0", d, 8'hFF);
        rd(8'hFF, d);  chk("R1", "array last byte", d, 8'hFF);
    endtask

    task automatic t_basic();
        logic [7:0] d; int bc, cc; logic fb;
        do_start();
        do_byte(8'h32, 8'hA0, 1'b0);
        do_byte(8'h9E, 8'hA1, 1'b0);   // address ignored (R2)
        do_byte(8'h00, 8'hA2, 1'b0);
        rd(8'h32, d); chk("R4", "array before STOP", d, 8'hFF);
        stop_and_wait(bc, cc, fb);
        chk("R4", "busy right after STOP", fb, 1);
        chk("R4", "busy cycle count", bc, PC + 1);
        chk("R5", "commit pulses", cc, 1);
        chk("R5", "commit page", last_page, 3);
        chk("R5", "commit mask", last_mask, 16'h001C);
        exp_mem[3*PB+2] = 8'hA0; exp_mem[3*PB+3] = 8'hA1; exp_mem[3*PB+4] = 8'hA2;
        check_page(3, "R2");
    endtask

    task automatic t_last_slot();
        int bc, cc; logic fb;
        do_start();
        do_byte(8'hFF, 8'h5C, 1'b0);
        stop_and_wait(bc, cc, fb);
        chk("R2", "last-slot commit page", last_page, PAGES - 1);
        chk("R2", "last-slot commit mask", last_mask, 16'h8000);
        exp_mem[(PAGES-1)*PB + 15] = 8'h5C;
        check_page(PAGES - 1, "R2");
    endtask

    task automatic t_wrap();
        int bc, cc; logic fb;
        do_start();
        do_byte(8'h5F, 8'h10, 1'b0);
        exp_mem[5*PB + 15] = 8'h10;
        for (int k = 1; k <= 16; k++) begin
            do_byte(8'hC7, 8'(8'h10 + k), 1'b0);
            exp_mem[5*PB + ((15 + k) % PB)] = 8'(8'h10 + k);
        end
        stop_and_wait(bc, cc, fb);
        chk("R3", "wrap commit page", last_page, 5);
        chk("R3", "wrap commit mask", last_mask, 16'hFFFF);
        check_page(5, "R3");
    endtask

    task automatic t_partial();
        int bc, cc; logic fb;
        do_start();
        do_byte(8'h33, 8'h5A, 1'b0);
        stop_and_wait(bc, cc, fb);
        chk("R6", "partial commit mask", last_mask, 16'h0008);
        exp_mem[3*PB + 3] = 8'h5A;
        check_page(3, "R6");
    endtask

    task automatic t_volatile();
        int bc, cc; logic fb;
        do_start();
        do_byte(8'h40, 8'h77, 1'b1);
        do_byte(8'h41, 8'h78, 1'b1);
        stop_and_wait(bc, cc, fb);
        chk("R7", "volatile-only busy cycles", bc, 0);
        chk("R7", "volatile-only commits", cc, 0);
        check_page(4, "R7");
    endtask

    task automatic t_empty();
        int bc, cc; logic fb;
        do_start();
        stop_and_wait(bc, cc, fb);
        chk("R8", "empty busy cycles", bc, 0);
        chk("R8", "empty commits", cc, 0);
    endtask

    task automatic t_abort();
        int bc, cc; logic fb;
        do_start();
        do_byte(8'h60, 8'h11, 1'b0);
        do_byte(8'h00, 8'h12, 1'b0);
        do_start();
        do_byte(8'h74, 8'h44, 1'b0);
        stop_and_wait(bc, cc, fb);
        chk("R9", "abort commits", cc, 1);
        chk("R9", "abort commit page", last_page, 7);
        chk("R9", "abort commit mask", last_mask, 16'h0010);
        exp_mem[7*PB + 4] = 8'h44;
        check_page(6, "R9");
        check_page(7, "R9");
    endtask

    task automatic t_busy_ignore();
        int b0, c0;
        do_start();
        do_byte(8'h80, 8'h88, 1'b0);
        b0 = busy_mon; c0 = commit_mon;
        do_stop();
        chk("R10", "busy before injection", busy, 1);
        do_start();
        do_byte(8'h90, 8'h99, 1'b0);
        do_stop();
        repeat (PC + 20) tick();
        chk("R10", "busy cycles with injection", busy_mon - b0, PC + 1);
        chk("R10", "commits with injection", commit_mon - c0, 1);
        chk("R10", "commit page with injection", last_page, 8);
        exp_mem[8*PB] = 8'h88;
        check_page(8, "R10");
        check_page(9, "R10");
    endtask

    task automatic t_idle_strobe();
        int bc, cc; logic fb;
        do_byte(8'hA0, 8'hAA, 1'b0);
        stop_and_wait(bc, cc, fb);
        chk("R11", "idle strobe busy cycles", bc, 0);
        do_start();
        stop_and_wait(bc, cc, fb);
        chk("R11", "idle strobe then empty txn commits", cc, 0);
        check_page(10, "R11");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < PAGES*PB; i++) exp_mem[i] = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_last_slot();
        t_wrap();
        t_partial();
        t_volatile();
        t_empty();
        t_abort();
        t_busy_ignore();
        t_idle_strobe();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule